// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for a synchronous burst SRAM. A cycle starts when either of two active-low address strobes is sampled low at a rising clock edge. The full input address is then captured as the burst base, and the burst beat count is cleared. On later edges with both strobes high, the active-low advance input steps the beat count by one. With advance high, the address holds. The beat count has two bits and wraps after the fourth beat, so a burst that keeps advancing cycles through the same four words.

Only the two low address bits are sequenced. The order input picks how they are formed from the base bits and the beat count. When it is low, the low bits are the base plus the beat count, modulo four (linear order). When it is high, the low bits are the base XOR the beat count (interleaved order). The order input should be tied high when unused, which gives the interleaved default. The upper address bits are passed through from the captured base unchanged. A strobe may be asserted on every cycle, so bursting is optional and loads can run back to back.

Top module: `burst_addr_ctr`

## Requirements
- R1: While rst_ni is low, and after its release with no strobe yet seen, addr_o is all zeros.
- R2: If strobe_proc_ni or strobe_ctrl_ni is low at a rising edge, addr_o equals the addr_i sampled at that edge from the next cycle on, in either order mode.
- R3: A strobe takes priority over advance: when a strobe and adv_ni are both low at an edge, addr_o equals the sampled addr_i with no step applied.
- R4: With both strobes high and adv_ni low at an edge, the beat count increases by one.
- R5: With both strobes and adv_ni high at an edge, and order_ni unchanged, addr_o does not change.
- R6: With order_ni high (interleaved), addr_o[1:0] equals the base low bits XOR the beat count; for a base of 1 the sequence is 1,0,3,2.
- R7: With order_ni low (linear), addr_o[1:0] equals the base low bits plus the beat count modulo 4; for a base of 1 the sequence is 1,2,3,0.
- R8: After the fourth beat, a further advance returns addr_o to the first address of the burst.
- R9: addr_o bits above bit 1 stay equal to the captured base for the whole burst.
- R10: Loads on consecutive cycles each take effect, with no idle cycle needed between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Base address for a new burst |
| strobe_proc_ni | input | 1 | Processor address strobe, active low |
| strobe_ctrl_ni | input | 1 | Controller address strobe, active low |
| adv_ni | input | 1 | Burst advance, active low |
| order_ni | input | 1 | Low selects linear order, high selects interleaved order |
| addr_o | output | ADDR_W | Current burst address |

## Verification
If the internal beat count is wrong, or the captured base is wrong, addr_o shows it in the first cycle after the edge that caused the error. A missed load shows the previous address in place of addr_i. A lost or doubled step puts the next low bits off their order's sequence. A bad wrap shows up on the fifth beat of a burst, where the first address should appear again. The tests use base values whose linear and interleaved sequences differ, so that an order mix-up is visible.

// File: rtl/bac_pkg.sv
package bac_pkg;
  localparam int unsigned BURST_W = 2;
  typedef logic [BURST_W-1:0] beat_t;
  typedef enum logic {ORD_LINEAR = 1'b0, ORD_INTERLEAVE = 1'b1} order_e;
endpackage

// File: rtl/bac_beat_ctr.sv
module bac_beat_ctr
  import bac_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  clr_i,
  input  logic  inc_i,
  output beat_t beat_o
);
  beat_t beat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    beat_q <= '0;
    else if (clr_i) beat_q <= '0;
    else if (inc_i) beat_q <= beat_q + 1'b1; // natural wrap after last beat
  end

  assign beat_o = beat_q;
endmodule

// File: rtl/bac_base_reg.sv
module bac_base_reg #(
  parameter int unsigned ADDR_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] base_o
);
  logic [ADDR_W-1:0] base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   base_q <= '0;
    else if (ld_i) base_q <= addr_i;
  end

  assign base_o = base_q;
endmodule

// File: rtl/bac_seq_map.sv
module bac_seq_map
  import bac_pkg::*;
(
  input  beat_t  base_i,
  input  beat_t  beat_i,
  input  order_e order_i,
  output beat_t  lsb_o
);
  beat_t lin, ilv;

  assign lin   = base_i + beat_i;
  assign ilv   = base_i ^ beat_i;
  assign lsb_o = (order_i == ORD_INTERLEAVE) ? ilv : lin;
endmodule

// File: rtl/burst_addr_ctr.sv
module burst_addr_ctr
  import bac_pkg::*;
#(
  parameter int unsigned ADDR_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              strobe_proc_ni,
  input  logic              strobe_ctrl_ni,
  input  logic              adv_ni,
  input  logic              order_ni,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned HI_W = ADDR_W - BURST_W;

  logic              load;
  logic              step;
  logic [ADDR_W-1:0] base;
  beat_t             beat;
  beat_t             lsb;
  order_e            order;

  assign load  = !strobe_proc_ni || !strobe_ctrl_ni;
  assign step  = !load && !adv_ni;
  assign order = order_e'(order_ni);

  bac_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ld_i  (load),
    .addr_i(addr_i),
    .base_o(base)
  );

  bac_beat_ctr u_beat (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (load),
    .inc_i (step),
    .beat_o(beat)
  );

  bac_seq_map u_map (
    .base_i (base[BURST_W-1:0]),
    .beat_i (beat),
    .order_i(order),
    .lsb_o  (lsb)
  );

  generate
    if (HI_W > 0) begin : g_hi
      assign addr_o = {base[ADDR_W-1:BURST_W], lsb};
    end else begin : g_lsb_only
      assign addr_o = lsb;
    end
  endgenerate
endmodule

// File: rtl/burst_addr_ctr_chk.sv
module burst_addr_ctr_chk #(
  parameter int unsigned ADDR_W = 18
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              strobe_proc_ni,
  input logic              strobe_ctrl_ni,
  input logic              adv_ni,
  input logic              order_ni,
  input logic [ADDR_W-1:0] addr_o
);
  logic       ld;
  logic [1:0] m_base;
  logic [1:0] m_beat;
  logic [1:0] lsb_next_lin;

  assign ld           = !strobe_proc_ni || !strobe_ctrl_ni;
  assign lsb_next_lin = addr_o[1:0] + 2'd1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_base <= '0;
      m_beat <= '0;
    end else if (ld) begin
      m_base <= addr_i[1:0];
      m_beat <= '0;
    end else if (!adv_ni) begin
      m_beat <= m_beat + 2'd1;
    end
  end

  p_reset_zero_r1: assert property (@(posedge clk_i) !rst_ni |-> addr_o == '0);

  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld |=> addr_o == $past(addr_i));

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld && adv_ni) |=> (order_ni != $past(order_ni)) || $stable(addr_o));

  p_upper_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld |=> addr_o[ADDR_W-1:2] == $past(addr_o[ADDR_W-1:2]));

  p_linear_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld && !adv_ni && !order_ni) |=> order_ni || addr_o[1:0] == $past(lsb_next_lin));

  p_interleave_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    order_ni |-> addr_o[1:0] == (m_base ^ m_beat));
endmodule

bind burst_addr_ctr burst_addr_ctr_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .addr_i        (addr_i),
  .strobe_proc_ni(strobe_proc_ni),
  .strobe_ctrl_ni(strobe_ctrl_ni),
  .adv_ni        (adv_ni),
  .order_ni      (order_ni),
  .addr_o        (addr_o)
);

// File: tb/tb_burst_addr_ctr.sv
module tb_burst_addr_ctr;
  localparam int unsigned AW = 18;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          strobe_proc_ni = 1'b1;
  logic          strobe_ctrl_ni = 1'b1;
  logic          adv_ni = 1'b1;
  logic          order_ni = 1'b1;
  logic [AW-1:0] addr_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk_i = ~clk_i; // 125 MHz

  burst_addr_ctr #(.ADDR_W(AW)) dut (
    .clk_i, .rst_ni, .addr_i, .strobe_proc_ni, .strobe_ctrl_ni,
    .adv_ni, .order_ni, .addr_o
  );

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // inputs change at negedge; one call = one rising edge, then back at negedge
  task automatic cyc();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic idle();
    strobe_proc_ni = 1'b1; strobe_ctrl_ni = 1'b1; adv_ni = 1'b1;
  endtask

  task automatic load(input logic [AW-1:0] a, input bit use_ctrl);
    addr_i = a;
    if (use_ctrl) strobe_ctrl_ni = 1'b0; else strobe_proc_ni = 1'b0;
    cyc();
    idle();
  endtask

  function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] b, input int beat, input bit ilv);
    logic [1:0] bt = 2'(beat);
    logic [1:0] l  = ilv ? (b[1:0] ^ bt) : (b[1:0] + bt);
    return {b[AW-1:2], l};
  endfunction

  task automatic t_reset();
    chk("R1 in reset", addr_o, '0);
    rst_ni = 1'b1;
    cyc(); cyc();
    chk("R1 after release", addr_o, '0);
  endtask

  task automatic t_load();
    order_ni = 1'b0;
    load(18'h2_a5c5, 1'b0);
    chk("R2 proc strobe linear", addr_o, 18'h2_a5c5);
    order_ni = 1'b1;
    load(18'h1_3377, 1'b1);
    chk("R2 ctrl strobe interleaved", addr_o, 18'h1_3377);
  endtask

  task automatic t_seq(input bit ilv, input logic [AW-1:0] b, input string req);
    order_ni = ilv;
    load(b, 1'b0);
    for (int i = 1; i < 4; i++) begin
      adv_ni = 1'b0; cyc(); adv_ni = 1'b1;
      chk(req, addr_o, exp_addr(b, i, ilv));
      chk("R9 upper bits", {addr_o[AW-1:2], 2'b00}, {b[AW-1:2], 2'b00});
    end
  endtask

  task automatic t_wrap();
    logic [AW-1:0] b = 18'h0_0f03;
    order_ni = 1'b0;
    load(b, 1'b1);
    adv_ni = 1'b0;
    for (int i = 0; i < 4; i++) cyc();
    adv_ni = 1'b1;
    chk("R8 wrap linear", addr_o, b);
    adv_ni = 1'b0; cyc(); adv_ni = 1'b1;
    chk("R4 step after wrap", addr_o, exp_addr(b, 1, 1'b0));
  endtask

  task automatic t_hold();
    logic [AW-1:0] b = 18'h3_0001;
    order_ni = 1'b1;
    load(b, 1'b0);
    adv_ni = 1'b0; cyc(); adv_ni = 1'b1;
    cyc(); cyc(); cyc();
    chk("R5 hold interleaved", addr_o, exp_addr(b, 1, 1'b1));
    adv_ni = 1'b0; cyc(); adv_ni = 1'b1;
    chk("R4 one step only", addr_o, exp_addr(b, 2, 1'b1));
  endtask

  task automatic t_priority();
    addr_i = 18'h1_1112; strobe_proc_ni = 1'b0; adv_ni = 1'b0;
    order_ni = 1'b0;
    cyc(); idle();
    chk("R3 strobe over advance", addr_o, 18'h1_1112);
  endtask

  task automatic t_back2back();
    strobe_ctrl_ni = 1'b0;
    addr_i = 18'h0_0011; cyc();
    chk("R10 first", addr_o, 18'h0_0011);
    strobe_ctrl_ni = 1'b1; strobe_proc_ni = 1'b0;
    addr_i = 18'h2_2222; cyc();
    chk("R10 second", addr_o, 18'h2_2222);
    addr_i = 18'h3_fffe; cyc();
    chk("R10 third", addr_o, 18'h3_fffe);
    idle();
  endtask

  initial begin
    @(negedge clk_i);
    t_reset();
    t_load();
    t_seq(1'b1, 18'h1_8001, "R6 interleaved base 1");
    t_seq(1'b0, 18'h1_8001, "R7 linear base 1");
    t_seq(1'b1, 18'h0_4443, "R6 interleaved base 3");
    t_seq(1'b0, 18'h0_4443, "R7 linear base 3");
    t_wrap();
    t_hold();
    t_priority();
    t_back2back();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule